// File: doc/BRIEF.md
# Dual-result carry-select adder

This block is a purely combinational adder for two unsigned operands of equal width. In one pass it delivers two results: the plain sum `a+b` and the incremented sum `a+b+1`. Each result has its own carry-out. It suits logic that needs both values in the same cycle, such as rounding after a mantissa add or a compare-and-step.

The operand is cut into consecutive segments. Each segment holds two ripple-carry adders, one fed a carry-in of zero and one fed a carry-in of one. Two independent selection chains walk the segments from least to most significant. The chain for the plain sum enters the lowest segment with a carry of zero, so it takes that segment's zero-carry adder. The chain for the incremented sum enters with a carry of one, so it takes the one-carry adder. In every later segment, the carry a chain selected in the segment below picks that segment's bits and carry-out. The longest path is one segment's ripple plus the chain of select multiplexers.

A parameter picks the segmentation. In nibble mode every segment is 4 bits wide, except the least significant one, which takes the remainder when the width is not a multiple of 4. Single-block mode is the default and uses one segment across the full width. Both operand widths are parameters, and a mismatch between them stops elaboration with an error.

Top module: `csca_compound_adder`

## Requirements
- R1: `sum_o` equals `(opa_i + opb_i) mod 2^WIDTH`, and `sum_co_o` equals bit WIDTH of the same addition done at WIDTH+1 bits.
- R2: `inc_o` equals `(opa_i + opb_i + 1) mod 2^WIDTH`, and `inc_co_o` equals bit WIDTH of that addition done at WIDTH+1 bits.
- R3: When `opa_i + opb_i` is all ones in WIDTH bits with no carry, `inc_o` is zero and `inc_co_o` is 1.
- R4: With both operands zero, `sum_o` is 0, `sum_co_o` is 0, `inc_o` is 1 and `inc_co_o` is 0.
- R5: In nibble mode (SPLIT = SPLIT_NIBBLE, encoding 1'b1), R1 and R2 hold for widths that are not a multiple of 4, where the lowest segment is shortened.
- R6: In single-block mode (SPLIT = SPLIT_SINGLE, encoding 1'b0, the default), R1 and R2 hold for every width.
- R7: Whenever `sum_co_o` is 1, `inc_co_o` is also 1.
- R8: With both operands all ones, `sum_o` is all ones except bit 0, which is 0, and `sum_co_o` is 1. `inc_o` is all ones and `inc_co_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First unsigned operand |
| opb_i | input | OPB_WIDTH | Second unsigned operand; must match WIDTH |
| sum_o | output | WIDTH | Plain sum a+b |
| sum_co_o | output | 1 | Carry-out of the plain sum |
| inc_o | output | WIDTH | Incremented sum a+b+1 |
| inc_co_o | output | 1 | Carry-out of the incremented sum |

## Verification
The assertions assume that both operands carry only known 0/1 values once driven, and that the two operand widths agree. Any other width pairing never reaches simulation, because elaboration rejects it. The bench drives every operand bit of every instance from a full 13-bit pattern that each instance truncates, so no X ever reaches an adder input. The same stimulus reaches five widths in each split mode, mixing seeded random operands with complementary all-ones pairs, zeros and maximum operands.

// File: rtl/csca_pkg.sv
package csca_pkg;

    typedef enum logic {
        SPLIT_SINGLE = 1'b0,
        SPLIT_NIBBLE = 1'b1
    } split_e;

    localparam int NIBBLE_W = 4;

    // Number of segments the operand is cut into.
    function automatic int seg_count(input int w, input split_e mode);
        if (mode == SPLIT_NIBBLE) begin
            return (w + NIBBLE_W - 1) / NIBBLE_W;
        end
        return 1;
    endfunction

    // Width of segment k; the lowest nibble segment absorbs the remainder.
    function automatic int seg_width(input int w, input split_e mode, input int k);
        int n;
        if (mode != SPLIT_NIBBLE) begin
            return w;
        end
        n = seg_count(w, mode);
        if (k == 0) begin
            return w - NIBBLE_W * (n - 1);
        end
        return NIBBLE_W;
    endfunction

    // Lowest bit index covered by segment k.
    function automatic int seg_lo(input int w, input split_e mode, input int k);
        if (k == 0) begin
            return 0;
        end
        return seg_width(w, mode, 0) + NIBBLE_W * (k - 1);
    endfunction

endpackage

// File: rtl/csca_ripple.sv
module csca_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ci_i,
    output logic [W-1:0] s_o,
    output logic         co_o
);
    logic [W:0] carry;

    assign carry[0] = ci_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic prop;
        assign prop         = a_i[i] ^ b_i[i];
        assign s_o[i]       = prop ^ carry[i];
        assign carry[i + 1] = (a_i[i] & b_i[i]) | (prop & carry[i]);
    end

    assign co_o = carry[W];
endmodule

// File: rtl/csca_segment.sv
module csca_segment #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] s_c0_o,
    output logic         co_c0_o,
    output logic [W-1:0] s_c1_o,
    output logic         co_c1_o
);
    csca_ripple #(.W(W)) u_rca_c0 (
        .a_i  (a_i),
        .b_i  (b_i),
        .ci_i (1'b0),
        .s_o  (s_c0_o),
        .co_o (co_c0_o)
    );

    csca_ripple #(.W(W)) u_rca_c1 (
        .a_i  (a_i),
        .b_i  (b_i),
        .ci_i (1'b1),
        .s_o  (s_c1_o),
        .co_o (co_c1_o)
    );
endmodule

// File: rtl/csca_select_chain.sv
module csca_select_chain #(
    parameter int               WIDTH     = 8,
    parameter csca_pkg::split_e SPLIT     = csca_pkg::SPLIT_SINGLE,
    parameter bit               START_ONE = 1'b0
) (
    input  logic [WIDTH-1:0]                              s_c0_i,
    input  logic [WIDTH-1:0]                              s_c1_i,
    input  logic [csca_pkg::seg_count(WIDTH, SPLIT)-1:0]  co_c0_i,
    input  logic [csca_pkg::seg_count(WIDTH, SPLIT)-1:0]  co_c1_i,
    output logic [WIDTH-1:0]                              res_o,
    output logic                                          co_o
);
    localparam int NSEG = csca_pkg::seg_count(WIDTH, SPLIT);

    logic [NSEG:0] sel;

    assign sel[0] = START_ONE;

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int LO = csca_pkg::seg_lo(WIDTH, SPLIT, k);
        localparam int SW = csca_pkg::seg_width(WIDTH, SPLIT, k);
        assign res_o[LO +: SW] = sel[k] ? s_c1_i[LO +: SW] : s_c0_i[LO +: SW];
        assign sel[k + 1]      = sel[k] ? co_c1_i[k] : co_c0_i[k];
    end

    assign co_o = sel[NSEG];
endmodule

// File: rtl/csca_compound_adder.sv
module csca_compound_adder #(
    parameter int               WIDTH     = 8,
    parameter int               OPB_WIDTH = WIDTH,
    parameter csca_pkg::split_e SPLIT     = csca_pkg::SPLIT_SINGLE
) (
    input  logic [WIDTH-1:0]     opa_i,
    input  logic [OPB_WIDTH-1:0] opb_i,
    output logic [WIDTH-1:0]     sum_o,
    output logic                 sum_co_o,
    output logic [WIDTH-1:0]     inc_o,
    output logic                 inc_co_o
);
    localparam int NSEG = csca_pkg::seg_count(WIDTH, SPLIT);

    if (OPB_WIDTH != WIDTH) begin : g_width_check
        $error("csca_compound_adder: operand widths differ");
    end

    logic [WIDTH-1:0] opb_w;
    logic [WIDTH-1:0] seg_s_c0;
    logic [WIDTH-1:0] seg_s_c1;
    logic [NSEG-1:0]  seg_co_c0;
    logic [NSEG-1:0]  seg_co_c1;

    assign opb_w = WIDTH'(opb_i);

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int LO = csca_pkg::seg_lo(WIDTH, SPLIT, k);
        localparam int SW = csca_pkg::seg_width(WIDTH, SPLIT, k);
        csca_segment #(.W(SW)) u_seg (
            .a_i     (opa_i[LO +: SW]),
            .b_i     (opb_w[LO +: SW]),
            .s_c0_o  (seg_s_c0[LO +: SW]),
            .co_c0_o (seg_co_c0[k]),
            .s_c1_o  (seg_s_c1[LO +: SW]),
            .co_c1_o (seg_co_c1[k])
        );
    end

    csca_select_chain #(.WIDTH(WIDTH), .SPLIT(SPLIT), .START_ONE(1'b0)) u_sum_chain (
        .s_c0_i  (seg_s_c0),
        .s_c1_i  (seg_s_c1),
        .co_c0_i (seg_co_c0),
        .co_c1_i (seg_co_c1),
        .res_o   (sum_o),
        .co_o    (sum_co_o)
    );

    csca_select_chain #(.WIDTH(WIDTH), .SPLIT(SPLIT), .START_ONE(1'b1)) u_inc_chain (
        .s_c0_i  (seg_s_c0),
        .s_c1_i  (seg_s_c1),
        .co_c0_i (seg_co_c0),
        .co_c1_i (seg_co_c1),
        .res_o   (inc_o),
        .co_o    (inc_co_o)
    );
endmodule

// File: rtl/csca_compound_adder_chk.sv
module csca_compound_adder_chk #(
    parameter int WIDTH     = 8,
    parameter int OPB_WIDTH = WIDTH
) (
    input logic [WIDTH-1:0]     opa_i,
    input logic [OPB_WIDTH-1:0] opb_i,
    input logic [WIDTH-1:0]     sum_o,
    input logic                 sum_co_o,
    input logic [WIDTH-1:0]     inc_o,
    input logic                 inc_co_o
);
    logic [WIDTH:0] ref_sum;
    logic [WIDTH:0] ref_inc;

    always_comb begin
        ref_sum = {1'b0, opa_i} + {1'b0, WIDTH'(opb_i)};
        ref_inc = ref_sum + 1'b1;
        if (!$isunknown({opa_i, opb_i})) begin
            assert_sum_ref_R1: assert ({sum_co_o, sum_o} == ref_sum)
                else $error("plain sum mismatch");
            assert_inc_ref_R2: assert ({inc_co_o, inc_o} == ref_inc)
                else $error("incremented sum mismatch");
            assert_pair_step_R2: assert ({inc_co_o, inc_o} == {sum_co_o, sum_o} + 1'b1)
                else $error("sum+1 chain not one above sum chain");
            if (!sum_co_o && (&sum_o)) begin
                assert_wrap_R3: assert (inc_o == '0 && inc_co_o)
                    else $error("all-ones sum did not wrap");
            end
            assert_carry_order_R7: assert (!sum_co_o || inc_co_o)
                else $error("sum carry set without incremented carry");
        end
    end
endmodule

bind csca_compound_adder csca_compound_adder_chk #(
    .WIDTH     (WIDTH),
    .OPB_WIDTH (OPB_WIDTH)
) u_chk (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .sum_o    (sum_o),
    .sum_co_o (sum_co_o),
    .inc_o    (inc_o),
    .inc_co_o (inc_co_o)
);

// File: tb/test_csca_compound_adder.sv
module test_csca_compound_adder;
    localparam int NCFG  = 10;
    localparam int MAXW  = 13;
    localparam int NRAND = 400;

    function automatic int cfg_width(input int g);
        case (g % 5)
            0: return 1;
            1: return 3;
            2: return 4;
            3: return 8;
            default: return 13;
        endcase
    endfunction

    function automatic bit cfg_nibble(input int g);
        return g >= 5;
    endfunction

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [MAXW-1:0] opa;
    logic [MAXW-1:0] opb;
    logic [NCFG-1:0][MAXW:0] got_sum;
    logic [NCFG-1:0][MAXW:0] got_inc;

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        localparam int GW = cfg_width(g);
        localparam csca_pkg::split_e GS = cfg_nibble(g) ? csca_pkg::SPLIT_NIBBLE
                                                        : csca_pkg::SPLIT_SINGLE;
        logic [GW-1:0] s_w;
        logic [GW-1:0] i_w;
        logic          sc_w;
        logic          ic_w;
        csca_compound_adder #(.WIDTH(GW), .SPLIT(GS)) i_csca_compound_adder (
            .opa_i    (opa[GW-1:0]),
            .opb_i    (opb[GW-1:0]),
            .sum_o    (s_w),
            .sum_co_o (sc_w),
            .inc_o    (i_w),
            .inc_co_o (ic_w)
        );
        assign got_sum[g] = (MAXW + 1)'({sc_w, s_w});
        assign got_inc[g] = (MAXW + 1)'({ic_w, i_w});
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic int wmask(input int w);
        return (1 << w) - 1;
    endfunction

    task automatic check(input int g, input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s cfg=%0d width=%0d nibble=%0d got=0x%0h expected=0x%0h",
                     req, g, cfg_width(g), cfg_nibble(g), got, exp);
        end
    endtask

    task automatic apply(input logic [MAXW-1:0] a, input logic [MAXW-1:0] b);
        @(posedge clk);
        opa <= a;
        opb <= b;
        @(negedge clk);
        for (int g = 0; g < NCFG; g++) begin
            int w;
            int ea;
            int eb;
            int es;
            int ei;
            string tag;
            w  = cfg_width(g);
            ea = int'(a) & wmask(w);
            eb = int'(b) & wmask(w);
            es = (ea + eb) & wmask(w + 1);
            ei = (ea + eb + 1) & wmask(w + 1);
            check(g, "R1", int'(got_sum[g]), es);
            check(g, "R2", int'(got_inc[g]), ei);
            tag = cfg_nibble(g) ? "R5" : "R6";
            check(g, tag, int'({got_inc[g], got_sum[g]}), (ei << (MAXW + 1)) | es);
            // R7: a set plain carry implies a set incremented carry
            check(g, "R7", int'(got_sum[g][w] && !got_inc[g][w]), 0);
        end
    endtask

    initial begin
        logic [MAXW-1:0] ones;
        ones = '1;
        opa  = '0;
        opb  = '0;
        void'($urandom(32'd20241005));
        repeat (2) @(posedge clk);

        // R4: zero operands
        apply('0, '0);
        for (int g = 0; g < NCFG; g++) begin
            check(g, "R4", int'(got_sum[g]), 0);
            check(g, "R4", int'(got_inc[g]), 1);
        end

        // R3: complementary operands give an all-ones sum at every width
        apply(13'h0AAA, 13'h1555);
        for (int g = 0; g < NCFG; g++) begin
            check(g, "R3", int'(got_inc[g]), 1 << cfg_width(g));
        end
        apply(ones, '0);
        for (int g = 0; g < NCFG; g++) begin
            check(g, "R3", int'(got_inc[g]), 1 << cfg_width(g));
        end

        // R8: both operands all ones
        apply(ones, ones);
        for (int g = 0; g < NCFG; g++) begin
            int w;
            w = cfg_width(g);
            check(g, "R8", int'(got_sum[g]), (1 << w) | (wmask(w) & ~1));
            check(g, "R8", int'(got_inc[g]), (1 << w) | wmask(w));
        end

        // carries crossing segment edges
        apply(13'h000F, 13'h0001);
        apply(13'h0FFF, 13'h0001);
        apply(13'h1001, 13'h0FFE);

        for (int n = 0; n < NRAND; n++) begin
            apply(MAXW'($urandom), MAXW'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before stimulus completed");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule